// File: doc/BRIEF.md
# Raster to Complex Coordinate Mapper

This block supplies the fractal iteration pipeline with one complex point per visible pixel of a 640 by 480 raster. A separate timing generator tells it when a frame begins, when each visible line begins and when each visible pixel is due. The block keeps a running real and imaginary value and adds or subtracts one pixel pitch per step, so no pixel position is ever multiplied.

The pitch is a power of two. It starts at 2^-8 (16 LSB) and halves for each zoom level, so the scale is applied with a shift. Six strobes come from board buttons: two change the zoom level and four move the view centre. Button strobes change only a pending copy of the view. The pending view is copied into the active view at the next frame start, so a frame is always drawn with one scale and one centre.

Top module: `cplx_view_mapper`

## Requirements
- R1: While reset is held, and until the first pixel strobe after reset, `c_re`, `c_im` and `c_valid` are all zero.
- R2: Coordinates are 14-bit two's complement values with 12 fractional bits. At zoom level 0 the pitch is 16 LSB. With the reset view, pixel (x, y) maps to re = (x-320)*16 and im = (240-y)*16, so pixel (320, 240) is 0 + 0i.
- R3: `zoom_in` raises the pending zoom level by one, up to 4. `zoom_out` lowers it by one, down to 0. The pitch is 16 >> level. When both strobes arrive in one cycle, the level does not change.
- R4: Each pan strobe moves the pending centre by 32 pitches, using the pending zoom level from before that cycle. `pan_right` and `pan_up` increase re and im; `pan_left` and `pan_down` decrease them. An opposing pair in the same cycle produces no move.
- R5: The pending centre saturates to the range [-8192, 8191] LSB in each axis.
- R6: Pending zoom and centre are applied only at `frame_start`. A strobe in the same cycle as `frame_start` waits for the following frame.
- R7: `line_start` reloads the real part to centre - 320 pitches. Each accepted pixel after it moves the real part up by one pitch.
- R8: The first `line_start` after `frame_start` uses im = centre + 240 pitches. This includes a `line_start` in the same cycle as `frame_start`. Each later `line_start` in the frame lowers im by one pitch.
- R9: The coordinate of an accepted pixel appears with `c_valid` high one cycle after `pix_step`. A `pix_step` in the same cycle as `line_start` or `frame_start` is dropped, and `c_valid` stays low.
- R10: A coordinate outside [-8192, 8191] LSB is output clamped to the nearer limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Strobe before the first line of a frame |
| line_start | input | 1 | Strobe before the first pixel of a line |
| pix_step | input | 1 | Strobe for one visible pixel |
| zoom_in | input | 1 | Button strobe: halve the pitch |
| zoom_out | input | 1 | Button strobe: double the pitch |
| pan_left | input | 1 | Button strobe: move the centre to lower re |
| pan_right | input | 1 | Button strobe: move the centre to higher re |
| pan_up | input | 1 | Button strobe: move the centre to higher im |
| pan_down | input | 1 | Button strobe: move the centre to lower im |
| c_re | output | 14 | Real part, signed, 12 fractional bits |
| c_im | output | 14 | Imaginary part, signed, 12 fractional bits |
| c_valid | output | 1 | Coordinate is valid this cycle |

## Verification
Two functions can fall in the same cycle. A button strobe can coincide with the frame start that latches the view. A pixel strobe can coincide with a line or frame start that reloads the accumulators. The bench drives a zoom strobe together with `frame_start`. It expects the frame that starts there to keep the old pitch and the next frame to use the new one. It also drives `pix_step` together with `line_start` and with `frame_start`, and expects no valid output in either case. A reference model, written from the requirements as pixel and line counts multiplied out, is compared with every output on every clock.

// File: rtl/cvm_pkg.sv
package cvm_pkg;

    localparam int COORD_W = 14;
    localparam int FRAC_W  = 12;
    localparam int ZOOM_W  = 3;
    localparam int ACC_W   = COORD_W + 2;

    typedef logic signed [COORD_W-1:0] coord_t;
    typedef logic signed [ACC_W-1:0]   acc_t;
    typedef logic        [ZOOM_W-1:0]  zoom_t;

    typedef struct packed {
        zoom_t  zoom;
        coord_t re;
        coord_t im;
    } view_t;

    localparam acc_t ACC_CMAX = acc_t'((2 ** (COORD_W - 1)) - 1);
    localparam acc_t ACC_CMIN = acc_t'(-(2 ** (COORD_W - 1)));

    function automatic coord_t clamp_coord(acc_t v);
        if (v > ACC_CMAX)      return coord_t'(ACC_CMAX);
        else if (v < ACC_CMIN) return coord_t'(ACC_CMIN);
        else                   return coord_t'(v);
    endfunction

endpackage

// File: rtl/cvm_view_ctrl.sv
module cvm_view_ctrl
    import cvm_pkg::*;
#(
    parameter int BASE_LOG = 4,
    parameter int PAN_PIX  = 32
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  frame_start,
    input  logic  zoom_in,
    input  logic  zoom_out,
    input  logic  pan_left,
    input  logic  pan_right,
    input  logic  pan_up,
    input  logic  pan_down,
    output view_t view
);

    localparam zoom_t ZOOM_MAX = zoom_t'(BASE_LOG);

    typedef struct packed {
        view_t pend;
        view_t act;
    } ctrl_t;

    ctrl_t st_d, st_q;
    acc_t  delta;
    acc_t  re_sum, im_sum;

    always_comb begin
        st_d  = st_q;
        delta = acc_t'(PAN_PIX) << (BASE_LOG - int'(st_q.pend.zoom));

        if (frame_start) begin
            st_d.act = st_q.pend;
        end

        if (zoom_in && !zoom_out && (st_q.pend.zoom < ZOOM_MAX)) begin
            st_d.pend.zoom = st_q.pend.zoom + zoom_t'(1);
        end else if (zoom_out && !zoom_in && (st_q.pend.zoom != '0)) begin
            st_d.pend.zoom = st_q.pend.zoom - zoom_t'(1);
        end

        re_sum = acc_t'(st_q.pend.re);
        if (pan_right && !pan_left)      re_sum = re_sum + delta;
        else if (pan_left && !pan_right) re_sum = re_sum - delta;
        st_d.pend.re = clamp_coord(re_sum);

        im_sum = acc_t'(st_q.pend.im);
        if (pan_up && !pan_down)         im_sum = im_sum + delta;
        else if (pan_down && !pan_up)    im_sum = im_sum - delta;
        st_d.pend.im = clamp_coord(im_sum);

        view = frame_start ? st_q.pend : st_q.act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: pending zoom never leaves its range
    p_zoom_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend.zoom <= ZOOM_MAX);

    // R6: active view changes only across a frame start
    p_frame_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(st_q.act));

endmodule

// File: rtl/cvm_raster_stepper.sv
module cvm_raster_stepper
    import cvm_pkg::*;
#(
    parameter int H_PIX    = 640,
    parameter int V_PIX    = 480,
    parameter int BASE_LOG = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  view_t  view,
    input  logic   frame_start,
    input  logic   line_start,
    input  logic   pix_step,
    output coord_t c_re,
    output coord_t c_im,
    output logic   c_valid
);

    localparam int H_HALF = H_PIX / 2;
    localparam int V_HALF = V_PIX / 2;

    typedef struct packed {
        acc_t   re_acc;
        acc_t   im_acc;
        logic   first_line;
        coord_t out_re;
        coord_t out_im;
        logic   out_vld;
    } step_t;

    step_t st_d, st_q;
    int    sh;
    acc_t  pitch, left_edge, top_edge;
    logic  take;

    always_comb begin
        st_d      = st_q;
        sh        = BASE_LOG - int'(view.zoom);
        pitch     = acc_t'(1) << sh;
        left_edge = acc_t'(view.re) - (acc_t'(H_HALF) << sh);
        top_edge  = acc_t'(view.im) + (acc_t'(V_HALF) << sh);
        take      = pix_step && !line_start && !frame_start;

        st_d.out_vld = take;
        if (take) begin
            st_d.out_re = clamp_coord(st_q.re_acc);
            st_d.out_im = clamp_coord(st_q.im_acc);
            st_d.re_acc = st_q.re_acc + pitch;
        end

        if (frame_start) begin
            st_d.im_acc     = top_edge;
            st_d.first_line = 1'b1;
        end

        if (line_start) begin
            st_d.re_acc = left_edge;
            if (frame_start || st_q.first_line) begin
                st_d.im_acc     = top_edge;
                st_d.first_line = 1'b0;
            end else begin
                st_d.im_acc = st_q.im_acc - pitch;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.first_line <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign c_re    = st_q.out_re;
    assign c_im    = st_q.out_im;
    assign c_valid = st_q.out_vld;

    // R9: reload cycles never produce a coordinate
    p_reload_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start || frame_start) |=> !c_valid);

    // R9: accepted pixel shows up one cycle later
    p_pix_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_step && !line_start && !frame_start) |=> c_valid);

    // R8: imaginary part constant along a run of pixels
    p_row_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && $past(take)) |=> $stable(c_im));

    // R7: real part never falls along a run of pixels
    p_step_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && $past(take)) |=> (c_re >= $past(c_re)));

endmodule

// File: rtl/cplx_view_mapper.sv
module cplx_view_mapper
    import cvm_pkg::*;
#(
    parameter int H_PIX    = 640,
    parameter int V_PIX    = 480,
    parameter int BASE_LOG = 4,
    parameter int PAN_PIX  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               line_start,
    input  logic               pix_step,
    input  logic               zoom_in,
    input  logic               zoom_out,
    input  logic               pan_left,
    input  logic               pan_right,
    input  logic               pan_up,
    input  logic               pan_down,
    output logic [COORD_W-1:0] c_re,
    output logic [COORD_W-1:0] c_im,
    output logic               c_valid
);

    view_t  view;
    coord_t re_s, im_s;

    cvm_view_ctrl #(
        .BASE_LOG (BASE_LOG),
        .PAN_PIX  (PAN_PIX)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .zoom_in     (zoom_in),
        .zoom_out    (zoom_out),
        .pan_left    (pan_left),
        .pan_right   (pan_right),
        .pan_up      (pan_up),
        .pan_down    (pan_down),
        .view        (view)
    );

    cvm_raster_stepper #(
        .H_PIX    (H_PIX),
        .V_PIX    (V_PIX),
        .BASE_LOG (BASE_LOG)
    ) u_step (
        .clk         (clk),
        .rst_n       (rst_n),
        .view        (view),
        .frame_start (frame_start),
        .line_start  (line_start),
        .pix_step    (pix_step),
        .c_re        (re_s),
        .c_im        (im_s),
        .c_valid     (c_valid)
    );

    assign c_re = re_s;
    assign c_im = im_s;

endmodule

// File: tb/cplx_view_mapper_test.sv
`timescale 1ns/1ps
module cplx_view_mapper_test;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic frame_start = 0, line_start = 0, pix_step = 0;
    logic zoom_in = 0, zoom_out = 0, pan_left = 0, pan_right = 0, pan_up = 0, pan_down = 0;
    logic [13:0] c_re, c_im;
    logic        c_valid;

    cplx_view_mapper uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
        .pix_step(pix_step), .zoom_in(zoom_in), .zoom_out(zoom_out),
        .pan_left(pan_left), .pan_right(pan_right), .pan_up(pan_up), .pan_down(pan_down),
        .c_re(c_re), .c_im(c_im), .c_valid(c_valid)
    );

    localparam logic [5:0] B_ZI = 6'b100000, B_ZO = 6'b010000, B_L = 6'b001000,
                           B_R  = 6'b000100, B_U  = 6'b000010, B_D = 6'b000001;

    int    tests = 0, fails = 0, cycles = 0;
    string phase = "R1";

    // behavioural reference state
    int m_pz, m_pre, m_pim, m_az, m_are, m_aim, m_x, m_y, m_first;
    int m_vld, m_ore, m_oim;

    function automatic int clampc(int v);
        if (v > 8191) return 8191;
        if (v < -8192) return -8192;
        return v;
    endfunction

    always @(posedge clk) begin : model
        int pitch, step;
        if (!rst_n) begin
            m_pz = 0; m_pre = 0; m_pim = 0; m_az = 0; m_are = 0; m_aim = 0;
            m_x = 0; m_y = 0; m_first = 1; m_vld = 0; m_ore = 0; m_oim = 0;
        end else begin
            pitch = 16 >> m_az;
            if (pix_step && !line_start && !frame_start) begin
                m_vld = 1;
                m_ore = clampc(m_are - 320 * pitch + m_x * pitch);
                m_oim = clampc(m_aim + 240 * pitch - m_y * pitch);
                m_x++;
            end else begin
                m_vld = 0;
            end
            if (frame_start) begin
                m_az = m_pz; m_are = m_pre; m_aim = m_pim; m_y = 0; m_first = 1;
            end
            if (line_start) begin
                m_x = 0;
                if (m_first != 0) m_first = 0;
                else m_y++;
            end
            step = 32 * (16 >> m_pz);
            if (pan_right && !pan_left) m_pre = clampc(m_pre + step);
            if (pan_left && !pan_right) m_pre = clampc(m_pre - step);
            if (pan_up && !pan_down)    m_pim = clampc(m_pim + step);
            if (pan_down && !pan_up)    m_pim = clampc(m_pim - step);
            if (zoom_in && !zoom_out && m_pz < 4) m_pz++;
            else if (zoom_out && !zoom_in && m_pz > 0) m_pz--;
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        tests++;
        if (int'(c_valid) != m_vld || int'($signed(c_re)) != m_ore ||
            int'($signed(c_im)) != m_oim) begin
            fails++;
            $display("FAIL %s: got vld=%0d re=%0d im=%0d, expected vld=%0d re=%0d im=%0d",
                     phase, c_valid, $signed(c_re), $signed(c_im), m_vld, m_ore, m_oim);
        end
    end

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(bit fs, bit ls, bit px, logic [5:0] b);
        frame_start = fs; line_start = ls; pix_step = px;
        {zoom_in, zoom_out, pan_left, pan_right, pan_up, pan_down} = b;
        @(negedge clk);
    endtask

    task automatic frame(int lines, int npix, bit combined);
        cyc(1'b1, combined, 1'b0, 6'b0);
        for (int l = 0; l < lines; l++) begin
            if (!(combined && l == 0)) cyc(1'b0, 1'b1, 1'b0, 6'b0);
            repeat (npix) cyc(1'b0, 1'b0, 1'b1, 6'b0);
        end
        cyc(1'b0, 1'b0, 1'b0, 6'b0);
    endtask

    task automatic press(logic [5:0] b, int n);
        repeat (n) cyc(1'b0, 1'b0, 1'b0, b);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles, expected under 150000", cycles);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        phase = "R1";
        repeat (3) @(negedge clk);
        chk("R1 valid", int'(c_valid), 0);
        chk("R1 re", int'($signed(c_re)), 0);
        rst_n = 1'b1;
        cyc(0, 0, 0, 6'b0);
        chk("R1 im", int'($signed(c_im)), 0);

        // R2 / R7 spot checks: first pixel and centre column of line 0
        phase = "R2";
        cyc(1, 0, 0, 6'b0);
        cyc(0, 1, 0, 6'b0);
        cyc(0, 0, 1, 6'b0);
        chk("R7 left edge", int'($signed(c_re)), -5120);
        chk("R8 top row", int'($signed(c_im)), 3840);
        repeat (320) cyc(0, 0, 1, 6'b0);
        chk("R2 centre re", int'($signed(c_re)), 0);
        cyc(0, 0, 0, 6'b0);

        phase = "R7"; frame(3, 640, 0);
        phase = "R8"; frame(480, 2, 0);
        chk("R8 bottom row", int'($signed(c_im)), 3840 - 479 * 16);
        frame(3, 10, 1);

        phase = "R3";
        press(B_ZI, 2); frame(2, 640, 0);
        press(B_ZI, 5); frame(2, 100, 0);
        press(B_ZI | B_ZO, 1); frame(2, 50, 0);
        press(B_ZO, 6); frame(2, 50, 0);

        phase = "R4";
        press(B_R, 3); press(B_U, 2); frame(2, 640, 0);
        press(B_L | B_R, 1); press(B_U | B_D, 1); frame(2, 20, 0);
        press(B_L, 2); press(B_D, 1); frame(2, 20, 0);

        phase = "R10";
        press(B_R, 20); press(B_U, 20); frame(3, 640, 0);
        chk("R10 right clamp", int'($signed(c_re)), 8191);
        press(B_L, 40); press(B_D, 40); frame(3, 640, 0);
        phase = "R5";
        press(B_ZI, 3); press(B_R, 10); frame(2, 640, 0);
        press(B_ZO, 3); press(B_R, 16); press(B_U, 16); frame(2, 30, 0);

        // R6: strobe together with frame start, and strobe mid-line
        phase = "R6";
        cyc(1, 0, 0, B_ZI);
        cyc(0, 1, 0, 6'b0);
        repeat (40) cyc(0, 0, 1, 6'b0);
        cyc(0, 0, 1, B_R);
        repeat (40) cyc(0, 0, 1, 6'b0);
        cyc(0, 1, 0, 6'b0);
        cyc(0, 0, 1, 6'b0);
        cyc(0, 0, 1, 6'b0);
        chk("R6 old pitch kept", int'($signed(c_re)) - m_ore, 0);
        cyc(0, 0, 0, 6'b0);
        frame(2, 640, 0);

        // R9: pixel strobe colliding with reload strobes
        phase = "R9";
        cyc(1, 0, 1, 6'b0);
        chk("R9 frame collide", int'(c_valid), 0);
        cyc(0, 1, 1, 6'b0);
        chk("R9 line collide", int'(c_valid), 0);
        repeat (5) cyc(0, 0, 1, 6'b0);
        cyc(0, 1, 1, 6'b0);
        chk("R9 second line", int'(c_valid), 0);
        repeat (5) cyc(0, 0, 1, 6'b0);
        cyc(0, 0, 0, 6'b0);

        finish_run();
    end

endmodule